// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor core that finishes each instruction within one clock period. It supports five operations: register add, register subtract, word load, word store, and branch-if-equal. Every cycle it fetches a word from an internal instruction store, decodes it, reads two source registers, and computes an ALU result. In that same cycle it either writes a register, writes data memory, or selects the next program counter. A separate adder forms PC+4 and another forms the branch destination, so neither has to wait for the ALU.

The instruction store and data store are internal word arrays. A test harness fills them through dedicated load ports while reset is held. Two debug read ports give combinational access to any register and any data word. The program counter is visible as an output.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset drives the program counter to 0 and clears every register to zero.
- R2: Opcode 0x00 with function code 0x20 writes rs+rt to rd, and with function code 0x22 writes rs-rt to rd. The result wraps modulo 2^32. The fields are rs in bits 25:21, rt in bits 20:16, rd in bits 15:11 and the function code in bits 5:0.
- R3: Opcode 0x23 loads a word into rt. The byte address is rs plus the sign-extended 16-bit immediate in bits 15:0, and bits [n+1:2] of that address select the data word.
- R4: Opcode 0x2B writes rt to the data word at rs plus the sign-extended immediate, and changes no register.
- R5: Opcode 0x04 compares rs and rt by subtraction. When they are equal, the next PC is (PC+4) + (sign-extended immediate << 2). Otherwise the next PC is PC+4.
- R6: The branch immediate is sign-extended before the shift. An immediate of 0xFFFC therefore moves the PC 16 bytes back from PC+4, and an immediate of 0xFFFF at address A branches back to A.
- R7: Register 0 always reads as zero, and writes addressed to it are discarded.
- R8: Any other opcode, and opcode 0x00 with any other function code, changes no register and no memory word, and only advances the PC by 4.
- R9: Apart from a taken branch, the PC advances by exactly 4 on each rising edge outside reset, and it always stays word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_ld_we | input | 1 | Write strobe for the instruction store |
| imem_ld_addr | input | IAW | Word index written in the instruction store |
| imem_ld_data | input | 32 | Instruction word to write |
| dmem_ld_we | input | 1 | Write strobe for the data store from outside; takes priority over the core |
| dmem_ld_addr | input | DAW | Word index written in the data store |
| dmem_ld_data | input | 32 | Data word to write |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_mem_sel | input | DAW | Data word index to observe |
| dbg_mem_data | output | 32 | Contents of the selected data word |
| pc_o | output | 32 | Current program counter |

## Verification
Each instruction commits within a single edge, so a wrong decode or a bad operand select shows on the debug ports one cycle after the faulty instruction. A wrong next-PC choice appears on pc_o on the very next edge. It also sends the rest of the program down another path, and the final register and memory contents then differ. Errors in sign extension or shift order show up as a branch that lands in the wrong place, which is caught at a known cycle of a backward loop. ALU faults are exposed by a sweep of operand pairs through add, subtract, store and compare, including equal pairs, zero, and sign-boundary values.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] FN_ADD    = 6'h20;
  localparam logic [5:0] FN_SUB    = 6'h22;

  typedef enum logic {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    alu_src;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    mem_to_reg;
    logic    reg_dst;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  // widen first, then scale words to bytes
  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc_inc,
                                                  input logic [15:0] imm);
    logic [XLEN-1:0] wide;
    wide = sext16(imm);
    return pc_inc + {wide[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input alu_op_e op);
    return (op == ALU_SUB) ? (a - b) : (a + b);
  endfunction
endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.reg_write = 1'b1;
          ctrl.reg_dst   = 1'b1;
          ctrl.alu_op    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_read   = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  input  logic [AW-1:0]   ra3,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  output logic [XLEN-1:0] rd3
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_calc(a, b, op);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_mem.sv
module sc_mem
  import sc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NRD   = 1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);
  logic [XLEN-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = words[raddr[g]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_ld_we,
  input  logic [IAW-1:0]  imem_ld_addr,
  input  logic [31:0]     imem_ld_data,
  input  logic            dmem_ld_we,
  input  logic [DAW-1:0]  dmem_ld_addr,
  input  logic [31:0]     dmem_ld_data,
  input  logic [4:0]      dbg_reg_sel,
  output logic [31:0]     dbg_reg_data,
  input  logic [DAW-1:0]  dbg_mem_sel,
  output logic [31:0]     dbg_mem_data,
  output logic [31:0]     pc_o
);
  logic [XLEN-1:0] pc, pc_plus4, br_target, pc_next;
  logic [XLEN-1:0] instr, imm_ext, alu_b, alu_y, wb_data, dm_rdata;
  logic [XLEN-1:0] rd1, rd2;
  logic [5:0]      opcode, funct;
  logic [4:0]      rs_idx, rt_idx, rd_idx, wb_idx;
  logic [15:0]     imm;
  ctrl_t           ctrl;
  logic            alu_zero, br_taken, rf_we, dm_we;
  logic [1:0][XLEN-1:0] dm_rd_bus;
  logic [DAW-1:0]  dm_waddr;
  logic [XLEN-1:0] dm_wdata;

  // fetch
  sc_mem #(.DEPTH(IMEM_DEPTH), .NRD(1)) u_imem (
    .clk(clk), .we(imem_ld_we), .waddr(imem_ld_addr), .wdata(imem_ld_data),
    .raddr(pc[IAW+1:2]), .rdata(instr)
  );

  assign opcode = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign imm    = instr[15:0];
  assign funct  = instr[5:0];

  sc_control u_ctrl (.opcode(opcode), .funct(funct), .ctrl(ctrl));

  assign wb_idx = ctrl.reg_dst ? rd_idx : rt_idx;
  assign rf_we  = ctrl.reg_write;

  sc_regfile #(.NREG(32)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(wb_idx), .wdata(wb_data),
    .ra1(rs_idx), .ra2(rt_idx), .ra3(dbg_reg_sel),
    .rd1(rd1), .rd2(rd2), .rd3(dbg_reg_data)
  );

  assign imm_ext = sext16(imm);
  assign alu_b   = ctrl.alu_src ? imm_ext : rd2;

  sc_alu u_alu (.a(rd1), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero));

  // data store: external load port wins over the core
  assign dm_we    = ctrl.mem_write;
  assign dm_waddr = dmem_ld_we ? dmem_ld_addr : alu_y[DAW+1:2];
  assign dm_wdata = dmem_ld_we ? dmem_ld_data : rd2;

  sc_mem #(.DEPTH(DMEM_DEPTH), .NRD(2)) u_dmem (
    .clk(clk), .we(dmem_ld_we | dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr({dbg_mem_sel, alu_y[DAW+1:2]}), .rdata(dm_rd_bus)
  );
  assign dm_rdata     = dm_rd_bus[0];
  assign dbg_mem_data = dm_rd_bus[1];

  assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

  // next PC: two dedicated adders beside the ALU
  assign pc_plus4  = pc + 32'd4;
  assign br_target = branch_dest(pc_plus4, imm);
  assign br_taken  = ctrl.branch & alu_zero;
  assign pc_next   = br_taken ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign pc_o = pc;
endmodule

module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] br_target,
  input logic        br_taken,
  input logic        rf_we,
  input logic        dm_we,
  input logic        mem_rd,
  input logic [4:0]  rs_idx,
  input logic [31:0] rd1,
  input logic [31:0] rd2
);
  // R1
  pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc == 32'd0);
  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> pc == $past(pc) + 32'd4);
  // R9
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
  // R5
  br_dest_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> pc == $past(br_target));
  // R5
  br_equal_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> rd1 == rd2);
  // R7
  reg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rs_idx == 5'd0 |-> rd1 == 32'd0);
  // R4
  store_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we && !mem_rd && !br_taken);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .br_target(br_target), .br_taken(br_taken),
  .rf_we(rf_we), .dm_we(dm_we), .mem_rd(ctrl.mem_read), .rs_idx(rs_idx),
  .rd1(rd1), .rd2(rd2)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IAW = 6;
  localparam int DAW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imem_ld_we = 1'b0;
  logic [IAW-1:0] imem_ld_addr = '0;
  logic [31:0] imem_ld_data = '0;
  logic dmem_ld_we = 1'b0;
  logic [DAW-1:0] dmem_ld_addr = '0;
  logic [31:0] dmem_ld_data = '0;
  logic [4:0] dbg_reg_sel = '0;
  logic [31:0] dbg_reg_data;
  logic [DAW-1:0] dbg_mem_sel = '0;
  logic [31:0] dbg_mem_data;
  logic [31:0] pc_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst(rst),
    .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_sel(dbg_mem_sel), .dbg_mem_data(dbg_mem_data), .pc_o(pc_o)
  );

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put_i(int a, logic [31:0] w);
    @(negedge clk);
    imem_ld_we = 1'b1; imem_ld_addr = a[IAW-1:0]; imem_ld_data = w;
    @(negedge clk);
    imem_ld_we = 1'b0;
  endtask
  task automatic put_d(int a, logic [31:0] w);
    @(negedge clk);
    dmem_ld_we = 1'b1; dmem_ld_addr = a[DAW-1:0]; dmem_ld_data = w;
    @(negedge clk);
    dmem_ld_we = 1'b0;
  endtask
  task automatic reg_chk(string req, int r, logic [31:0] exp);
    dbg_reg_sel = r[4:0]; #1;
    check(req, dbg_reg_data, exp);
  endtask
  task automatic mem_chk(string req, int a, logic [31:0] exp);
    dbg_mem_sel = a[DAW-1:0]; #1;
    check(req, dbg_mem_data, exp);
  endtask
  task automatic run(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] vals [6];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFFFFFF;
    vals[3] = 32'h80000000; vals[4] = 32'hFFFFFFFF; vals[5] = 32'h12345678;

    // program 1: loop, stores, forward branch, no-ops
    rst = 1'b1;
    put_i(0,  i_ins(6'h23, 0, 1, 16'd0));
    put_i(1,  i_ins(6'h23, 0, 2, 16'd4));
    put_i(2,  r_ins(0, 0, 3, 6'h20));
    put_i(3,  i_ins(6'h23, 0, 4, 16'd8));
    put_i(4,  r_ins(3, 2, 3, 6'h20));
    put_i(5,  r_ins(1, 4, 1, 6'h22));
    put_i(6,  i_ins(6'h04, 1, 0, 16'd1));
    put_i(7,  i_ins(6'h04, 0, 0, 16'hFFFC));
    put_i(8,  i_ins(6'h2B, 0, 3, 16'd12));
    put_i(9,  r_ins(2, 2, 0, 6'h20));
    put_i(10, r_ins(0, 2, 5, 6'h22));
    put_i(11, {6'h3F, 26'h0000421});
    put_i(12, r_ins(2, 2, 6, 6'h25));
    put_i(13, i_ins(6'h04, 2, 1, 16'd5));
    put_i(14, i_ins(6'h04, 2, 2, 16'd3));
    put_i(15, r_ins(2, 2, 7, 6'h20));
    put_i(16, r_ins(2, 2, 7, 6'h20));
    put_i(17, r_ins(2, 2, 7, 6'h20));
    put_i(18, i_ins(6'h23, 0, 8, 16'd12));
    put_i(19, i_ins(6'h04, 0, 0, 16'hFFFF));
    put_d(0, 32'd5); put_d(1, 32'd7); put_d(2, 32'd1); put_d(3, 32'd0);
    @(negedge clk);
    check("R1 pc in reset", pc_o, 32'd0);
    reg_chk("R1 register cleared", 3, 32'd0);
    rst = 1'b0;
    run(1);
    check("R9 pc after first edge", pc_o, 32'd4);
    run(7);
    check("R6 backward branch lands at loop head", pc_o, 32'd16);
    run(60);
    check("R6 self branch holds pc", pc_o, 32'd76);
    reg_chk("R2 sub counter", 1, 32'd0);
    reg_chk("R3 load", 2, 32'd7);
    reg_chk("R2 add accumulate", 3, 32'd35);
    reg_chk("R2 sub negative", 5, 32'hFFFFFFF9);
    reg_chk("R7 r0 write dropped", 0, 32'd0);
    reg_chk("R8 unknown funct no write", 6, 32'd0);
    reg_chk("R5 forward branch skipped", 7, 32'd0);
    reg_chk("R3 load after store", 8, 32'd35);
    mem_chk("R4 store word", 3, 32'd35);
    mem_chk("R8 unknown opcode no store", 0, 32'd5);

    // program 2: operand sweep
    rst = 1'b1;
    put_i(0, i_ins(6'h23, 0, 1, 16'd0));
    put_i(1, i_ins(6'h23, 0, 2, 16'd4));
    put_i(2, r_ins(1, 2, 3, 6'h20));
    put_i(3, r_ins(1, 2, 4, 6'h22));
    put_i(4, i_ins(6'h2B, 0, 3, 16'd8));
    put_i(5, i_ins(6'h2B, 0, 4, 16'd12));
    put_i(6, i_ins(6'h04, 1, 2, 16'd1));
    put_i(7, i_ins(6'h04, 0, 0, 16'hFFFF));
    put_i(8, i_ins(6'h04, 0, 0, 16'hFFFF));
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        rst = 1'b1;
        put_d(0, vals[i]); put_d(1, vals[j]); put_d(2, 32'd0); put_d(3, 32'd0);
        rst = 1'b0;
        run(12);
        reg_chk("R2 add sweep", 3, vals[i] + vals[j]);
        reg_chk("R2 sub sweep", 4, vals[i] - vals[j]);
        mem_chk("R4 store sum", 2, vals[i] + vals[j]);
        mem_chk("R4 store diff", 3, vals[i] - vals[j]);
        check("R5 compare outcome", pc_o, (vals[i] == vals[j]) ? 32'd32 : 32'd28);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule